// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block steers a multicycle processor datapath from a small microinstruction store. A micro-address register selects one microinstruction. The microinstruction carries encoded datapath control fields and a 2-bit sequencing field that decides where control goes next. There are four next-address rules: return to the fetch entry, jump through a first opcode-indexed dispatch table, jump through a second dispatch table, or step to the following entry.

The store holds ten entries:

| Address | Entry |
|---|---|
| 0 | fetch |
| 1 | decode |
| 2 | memory-address |
| 3 | load read |
| 4 | load write-back |
| 5 | store |
| 6 | register-format execute |
| 7 | register-format completion |
| 8 | branch |
| 9 | jump |

The store is built from constant logic. Its field encodings are expanded into individual strobes and selector codes for the datapath. Those strobes and codes are registered together with the micro-address. The datapath and instruction memory sit outside this block. They supply only the 6-bit opcode of the instruction held in the instruction register.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the sequencer loads micro-address 0, and the outputs become those of the fetch entry at that same edge. Reset is synchronous.
- R2: The sequencing field "increment" (code 3) makes the next micro-address the current one plus one. The fetch, load-read and register-execute entries use it, giving the transitions 0→1, 3→4 and 6→7.
- R3: At decode (entry 1), the sequencing field "dispatch 1" (code 1) indexes the first table by `opcode`:
  - 6'h00 goes to entry 6.
  - 6'h02 goes to entry 9.
  - 6'h04 goes to entry 8.
  - 6'h23 and 6'h2B both go to entry 2.
- R4: At the memory-address entry (2), the sequencing field "dispatch 2" (code 2) indexes the second table by the `opcode` present during that cycle. 6'h23 goes to entry 3 and 6'h2B goes to entry 5.
- R5: A dispatch on an opcode that is not in the selected table makes the next micro-address 0.
- R6: Entries 4, 5, 7, 8 and 9 use the sequencing field "zero" (code 0) and return to entry 0. The micro-address never leaves the range 0..9.
- R7: In fetch, the outputs are `mem_read`, `ir_write` and `pc_write` high, with `addr_from_alu` low. The selector codes are `a_from_reg`=0, `b_sel`=01 (constant four), `alu_op`=00 (add) and `pc_sel`=00 (ALU result).
- R8: In decode, `alu_op`=00, `a_from_reg`=0 and `b_sel`=11 (shifted immediate), and no write or memory strobe is high.
- R9: The ALU operand entries drive `a_from_reg`=1 together with these codes:
  - Memory-address: `b_sel`=10 (immediate) and `alu_op`=00.
  - Register execute: `b_sel`=00 (register) and `alu_op`=10 (function field).
  - Branch: `b_sel`=00, `alu_op`=01 (subtract), `pc_write_cond`=1 and `pc_sel`=01 (ALU output register).
- R10: The memory and register-file entries drive the following strobes:
  - Load read: `mem_read` and `addr_from_alu`.
  - Store: `mem_write` and `addr_from_alu`.
  - Load write-back: `reg_write` and `wb_from_mem`, with `dest_rd`=0.
  - Register completion: `reg_write` with `dest_rd`=1 and `wb_from_mem`=0.
  - `mem_read` and `mem_write` are never high together.
- R11: In the jump entry, `pc_write`=1 and `pc_sel`=10 (jump target), and every other strobe is low.
- R12: `opcode` is ignored in every entry other than 1 and 2. Every output, including `upc`, changes only at a rising edge, and the control outputs always match the entry shown on `upc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W (6) | Opcode of the current instruction |
| pc_write | output | 1 | Unconditional program-counter write |
| pc_write_cond | output | 1 | Program-counter write when the ALU result is zero |
| addr_from_alu | output | 1 | Memory address from the ALU output register (0 = PC) |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| ir_write | output | 1 | Instruction register load |
| reg_write | output | 1 | Register file write |
| wb_from_mem | output | 1 | Write-back data from memory data register (0 = ALU output) |
| dest_rd | output | 1 | Write destination from rd field (0 = rt field) |
| a_from_reg | output | 1 | First ALU operand from register A (0 = PC) |
| b_sel | output | 2 | Second ALU operand select |
| alu_op | output | 2 | ALU operation class |
| pc_sel | output | 2 | Program-counter source select |
| upc | output | UPC_W (4) | Current micro-address |

## Verification
The assertions take for granted that `opcode` is a defined value at every edge where the micro-address is 1 or 2. They also assume reset is asserted at the first edge, so that the micro-address starts inside the populated range. The stimulus holds `opcode` stable and known throughout each decode and memory-address cycle. It drives deliberately unrelated opcodes in the other cycles of each instruction and during its mixed-opcode cases. Reset is asserted once mid-instruction, and it is always held across a full clock edge.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Micro-address of each store entry
  localparam int E_FETCH   = 0;
  localparam int E_DECODE  = 1;
  localparam int E_MADDR   = 2;
  localparam int E_LDREAD  = 3;
  localparam int E_LDWB    = 4;
  localparam int E_STORE   = 5;
  localparam int E_REXEC   = 6;
  localparam int E_RDONE   = 7;
  localparam int E_BRANCH  = 8;
  localparam int E_JUMP    = 9;
  localparam int N_ENTRIES = 10;

  // Next-address rule (sequencing field, last in the word)
  typedef enum logic [1:0] {
    SEQ_ZERO  = 2'd0,
    SEQ_DISP1 = 2'd1,
    SEQ_DISP2 = 2'd2,
    SEQ_NEXT  = 2'd3
  } seq_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_SUB  = 2'd1,
    ALU_FUNC = 2'd2,
    ALU_RSV  = 2'd3
  } alu_e;

  typedef enum logic [1:0] {
    B_REG    = 2'd0,
    B_FOUR   = 2'd1,
    B_IMM    = 2'd2,
    B_IMM_SH = 2'd3
  } srcb_e;

  typedef enum logic [1:0] {
    PCS_ALU    = 2'd0,
    PCS_ALUOUT = 2'd1,
    PCS_JUMP   = 2'd2,
    PCS_RSV    = 2'd3
  } pcsrc_e;

  // Memory activity: never more than one at a time, so one field
  typedef enum logic [1:0] {
    MEM_NONE  = 2'd0,
    MEM_FETCH = 2'd1,
    MEM_LOAD  = 2'd2,
    MEM_STORE = 2'd3
  } mem_e;

  // Register-file write: source and destination are tied together
  typedef enum logic [1:0] {
    RF_NONE   = 2'd0,
    RF_ALU_RD = 2'd1,
    RF_MDR_RT = 2'd2,
    RF_RSV    = 2'd3
  } rf_e;

  typedef enum logic [1:0] {
    PCW_NONE   = 2'd0,
    PCW_ALWAYS = 2'd1,
    PCW_ZERO   = 2'd2,
    PCW_RSV    = 2'd3
  } pcw_e;

  // Encoded microinstruction: ALU fields first, sequencing last
  typedef struct packed {
    alu_e   alu;
    logic   src_a;
    srcb_e  src_b;
    pcsrc_e pc_src;
    mem_e   mem;
    rf_e    rf;
    pcw_e   pcw;
    seq_e   seq;
  } uinst_t;

  // Decoded datapath controls
  typedef struct packed {
    logic       pc_write;
    logic       pc_write_cond;
    logic       addr_from_alu;
    logic       mem_read;
    logic       mem_write;
    logic       ir_write;
    logic       reg_write;
    logic       wb_from_mem;
    logic       dest_rd;
    logic       a_from_reg;
    logic [1:0] b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_sel;
  } ctrl_t;

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int UPC_W = 4
) (
  input  logic [UPC_W-1:0] addr,
  output uinst_t           word
);

  // Constant microprogram; unpopulated addresses read as all-zero,
  // which is a no-operation that returns to fetch.
  always_comb begin
    word = '0;
    case (addr)
      UPC_W'(E_FETCH): begin
        word.alu    = ALU_ADD;
        word.src_a  = 1'b0;
        word.src_b  = B_FOUR;
        word.pc_src = PCS_ALU;
        word.mem    = MEM_FETCH;
        word.pcw    = PCW_ALWAYS;
        word.seq    = SEQ_NEXT;
      end
      UPC_W'(E_DECODE): begin
        word.alu    = ALU_ADD;
        word.src_a  = 1'b0;
        word.src_b  = B_IMM_SH;
        word.seq    = SEQ_DISP1;
      end
      UPC_W'(E_MADDR): begin
        word.alu    = ALU_ADD;
        word.src_a  = 1'b1;
        word.src_b  = B_IMM;
        word.seq    = SEQ_DISP2;
      end
      UPC_W'(E_LDREAD): begin
        word.mem    = MEM_LOAD;
        word.seq    = SEQ_NEXT;
      end
      UPC_W'(E_LDWB): begin
        word.rf     = RF_MDR_RT;
        word.seq    = SEQ_ZERO;
      end
      UPC_W'(E_STORE): begin
        word.mem    = MEM_STORE;
        word.seq    = SEQ_ZERO;
      end
      UPC_W'(E_REXEC): begin
        word.alu    = ALU_FUNC;
        word.src_a  = 1'b1;
        word.src_b  = B_REG;
        word.seq    = SEQ_NEXT;
      end
      UPC_W'(E_RDONE): begin
        word.rf     = RF_ALU_RD;
        word.seq    = SEQ_ZERO;
      end
      UPC_W'(E_BRANCH): begin
        word.alu    = ALU_SUB;
        word.src_a  = 1'b1;
        word.src_b  = B_REG;
        word.pc_src = PCS_ALUOUT;
        word.pcw    = PCW_ZERO;
        word.seq    = SEQ_ZERO;
      end
      UPC_W'(E_JUMP): begin
        word.pc_src = PCS_JUMP;
        word.pcw    = PCW_ALWAYS;
        word.seq    = SEQ_ZERO;
      end
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int         UPC_W    = 4,
  parameter int         OP_W     = 6,
  parameter int         TABLE    = 1,
  parameter logic [5:0] OP_RFMT  = 6'h00,
  parameter logic [5:0] OP_JUMP  = 6'h02,
  parameter logic [5:0] OP_BEQ   = 6'h04,
  parameter logic [5:0] OP_LOAD  = 6'h23,
  parameter logic [5:0] OP_STORE = 6'h2B
) (
  input  logic [OP_W-1:0]  opcode,
  output logic [UPC_W-1:0] target
);

  generate
    if (TABLE == 1) begin : g_first
      // Instruction-class split taken at decode
      always_comb begin
        if (opcode == OP_W'(OP_RFMT))       target = UPC_W'(E_REXEC);
        else if (opcode == OP_W'(OP_JUMP))  target = UPC_W'(E_JUMP);
        else if (opcode == OP_W'(OP_BEQ))   target = UPC_W'(E_BRANCH);
        else if (opcode == OP_W'(OP_LOAD))  target = UPC_W'(E_MADDR);
        else if (opcode == OP_W'(OP_STORE)) target = UPC_W'(E_MADDR);
        else                                target = '0;
      end
    end else begin : g_second
      // Load/store split taken after address computation
      always_comb begin
        if (opcode == OP_W'(OP_LOAD))       target = UPC_W'(E_LDREAD);
        else if (opcode == OP_W'(OP_STORE)) target = UPC_W'(E_STORE);
        else                                target = '0;
      end
    end
  endgenerate

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int UPC_W = 4
) (
  input  logic             rst,
  input  seq_e             seq,
  input  logic [UPC_W-1:0] cur,
  input  logic [UPC_W-1:0] disp1,
  input  logic [UPC_W-1:0] disp2,
  output logic [UPC_W-1:0] nxt
);

  // Four-way address select; reset overrides every rule
  always_comb begin
    if (rst) begin
      nxt = '0;
    end else begin
      case (seq)
        SEQ_ZERO:  nxt = '0;
        SEQ_DISP1: nxt = disp1;
        SEQ_DISP2: nxt = disp2;
        SEQ_NEXT:  nxt = cur + UPC_W'(1);
        default:   nxt = '0;
      endcase
    end
  end

endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  uinst_t word,
  output ctrl_t  ctrl
);

  always_comb begin
    ctrl.pc_write      = (word.pcw == PCW_ALWAYS);
    ctrl.pc_write_cond = (word.pcw == PCW_ZERO);
    ctrl.mem_read      = (word.mem == MEM_FETCH) || (word.mem == MEM_LOAD);
    ctrl.ir_write      = (word.mem == MEM_FETCH);
    ctrl.mem_write     = (word.mem == MEM_STORE);
    ctrl.addr_from_alu = (word.mem == MEM_LOAD) || (word.mem == MEM_STORE);
    ctrl.reg_write     = (word.rf == RF_ALU_RD) || (word.rf == RF_MDR_RT);
    ctrl.wb_from_mem   = (word.rf == RF_MDR_RT);
    ctrl.dest_rd       = (word.rf == RF_ALU_RD);
    ctrl.a_from_reg    = word.src_a;
    ctrl.b_sel         = word.src_b;
    ctrl.alu_op        = word.alu;
    ctrl.pc_sel        = word.pc_src;
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int         UPC_W    = 4,
  parameter int         OP_W     = 6,
  parameter logic [5:0] OP_RFMT  = 6'h00,
  parameter logic [5:0] OP_JUMP  = 6'h02,
  parameter logic [5:0] OP_BEQ   = 6'h04,
  parameter logic [5:0] OP_LOAD  = 6'h23,
  parameter logic [5:0] OP_STORE = 6'h2B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  output logic             pc_write,
  output logic             pc_write_cond,
  output logic             addr_from_alu,
  output logic             mem_read,
  output logic             mem_write,
  output logic             ir_write,
  output logic             reg_write,
  output logic             wb_from_mem,
  output logic             dest_rd,
  output logic             a_from_reg,
  output logic [1:0]       b_sel,
  output logic [1:0]       alu_op,
  output logic [1:0]       pc_sel,
  output logic [UPC_W-1:0] upc
);

  localparam int N_DISP = 2;

  logic [UPC_W-1:0] upc_q;
  logic [UPC_W-1:0] upc_d;
  seq_e             seq_q;
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_d;
  uinst_t           word_d;
  logic [UPC_W-1:0] disp_tgt [N_DISP];

  generate
    for (genvar t = 0; t < N_DISP; t++) begin : g_disp
      useq_dispatch #(
        .UPC_W(UPC_W), .OP_W(OP_W), .TABLE(t + 1),
        .OP_RFMT(OP_RFMT), .OP_JUMP(OP_JUMP), .OP_BEQ(OP_BEQ),
        .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE)
      ) u_tbl (
        .opcode (opcode),
        .target (disp_tgt[t])
      );
    end
  endgenerate

  useq_next #(.UPC_W(UPC_W)) u_next (
    .rst   (rst),
    .seq   (seq_q),
    .cur   (upc_q),
    .disp1 (disp_tgt[0]),
    .disp2 (disp_tgt[1]),
    .nxt   (upc_d)
  );

  // Store is read at the next address, so its output register
  // lines up with the micro-address register (synchronous-read ROM).
  useq_store #(.UPC_W(UPC_W)) u_store (
    .addr (upc_d),
    .word (word_d)
  );

  useq_decode u_dec (
    .word (word_d),
    .ctrl (ctrl_d)
  );

  always_ff @(posedge clk) begin
    upc_q  <= upc_d;
    seq_q  <= word_d.seq;
    ctrl_q <= ctrl_d;
  end

  assign upc           = upc_q;
  assign pc_write      = ctrl_q.pc_write;
  assign pc_write_cond = ctrl_q.pc_write_cond;
  assign addr_from_alu = ctrl_q.addr_from_alu;
  assign mem_read      = ctrl_q.mem_read;
  assign mem_write     = ctrl_q.mem_write;
  assign ir_write      = ctrl_q.ir_write;
  assign reg_write     = ctrl_q.reg_write;
  assign wb_from_mem   = ctrl_q.wb_from_mem;
  assign dest_rd       = ctrl_q.dest_rd;
  assign a_from_reg    = ctrl_q.a_from_reg;
  assign b_sel         = ctrl_q.b_sel;
  assign alu_op        = ctrl_q.alu_op;
  assign pc_sel        = ctrl_q.pc_sel;

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int         UPC_W    = 4,
  parameter int         OP_W     = 6,
  parameter logic [5:0] OP_RFMT  = 6'h00,
  parameter logic [5:0] OP_JUMP  = 6'h02,
  parameter logic [5:0] OP_BEQ   = 6'h04,
  parameter logic [5:0] OP_LOAD  = 6'h23,
  parameter logic [5:0] OP_STORE = 6'h2B
) (
  input logic             clk,
  input logic             rst,
  input logic [OP_W-1:0]  opcode,
  input logic [UPC_W-1:0] upc,
  input logic             pc_write,
  input logic             pc_write_cond,
  input logic             mem_read,
  input logic             mem_write,
  input logic             ir_write
);

  logic known1;
  logic known2;
  assign known1 = (opcode == OP_W'(OP_RFMT)) || (opcode == OP_W'(OP_JUMP)) ||
                  (opcode == OP_W'(OP_BEQ))  || (opcode == OP_W'(OP_LOAD)) ||
                  (opcode == OP_W'(OP_STORE));
  assign known2 = (opcode == OP_W'(OP_LOAD)) || (opcode == OP_W'(OP_STORE));

  a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (upc == '0 && ir_write && pc_write));

  a_r2_step_fetch: assert property (@(posedge clk) disable iff (rst)
    (upc == UPC_W'(0)) |=> (upc == UPC_W'(1)));

  a_r2_step_load: assert property (@(posedge clk) disable iff (rst)
    (upc == UPC_W'(3)) |=> (upc == UPC_W'(4)));

  a_r2_step_rexec: assert property (@(posedge clk) disable iff (rst)
    (upc == UPC_W'(6)) |=> (upc == UPC_W'(7)));

  a_r3_branch_target: assert property (@(posedge clk) disable iff (rst)
    (upc == UPC_W'(1) && opcode == OP_W'(OP_BEQ)) |=> (upc == UPC_W'(8)));

  a_r3_mem_target: assert property (@(posedge clk) disable iff (rst)
    (upc == UPC_W'(1) && known2) |=> (upc == UPC_W'(2)));

  a_r4_split: assert property (@(posedge clk) disable iff (rst)
    (upc == UPC_W'(2) && known2) |=> (upc == UPC_W'(3) || upc == UPC_W'(5)));

  a_r5_miss1: assert property (@(posedge clk) disable iff (rst)
    (upc == UPC_W'(1) && !known1) |=> (upc == '0));

  a_r5_miss2: assert property (@(posedge clk) disable iff (rst)
    (upc == UPC_W'(2) && !known2) |=> (upc == '0));

  a_r6_complete: assert property (@(posedge clk) disable iff (rst)
    (upc == UPC_W'(4) || upc == UPC_W'(5) || upc == UPC_W'(7) ||
     upc == UPC_W'(8) || upc == UPC_W'(9)) |=> (upc == '0));

  a_r6_in_range: assert property (@(posedge clk) disable iff (rst)
    upc <= UPC_W'(9));

  a_r10_mem_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_read && mem_write));

  a_r9_pc_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_write, pc_write_cond}));

endmodule

bind useq_ctrl useq_ctrl_chk #(
  .UPC_W(UPC_W), .OP_W(OP_W), .OP_RFMT(OP_RFMT), .OP_JUMP(OP_JUMP),
  .OP_BEQ(OP_BEQ), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .opcode        (opcode),
  .upc           (upc),
  .pc_write      (pc_write),
  .pc_write_cond (pc_write_cond),
  .mem_read      (mem_read),
  .mem_write     (mem_write),
  .ir_write      (ir_write)
);

// File: tb/sim_useq_ctrl.sv
`timescale 1ns/1ps
module sim_useq_ctrl;

  localparam logic [5:0] OPR = 6'h00;
  localparam logic [5:0] OPJ = 6'h02;
  localparam logic [5:0] OPB = 6'h04;
  localparam logic [5:0] OPL = 6'h23;
  localparam logic [5:0] OPS = 6'h2B;
  localparam logic [5:0] JNK = 6'h3F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic pc_write, pc_write_cond, addr_from_alu, mem_read, mem_write, ir_write;
  logic reg_write, wb_from_mem, dest_rd, a_from_reg;
  logic [1:0] b_sel, alu_op, pc_sel;
  logic [3:0] upc;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  useq_ctrl u0 (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_write(pc_write), .pc_write_cond(pc_write_cond),
    .addr_from_alu(addr_from_alu), .mem_read(mem_read), .mem_write(mem_write),
    .ir_write(ir_write), .reg_write(reg_write), .wb_from_mem(wb_from_mem),
    .dest_rd(dest_rd), .a_from_reg(a_from_reg), .b_sel(b_sel),
    .alu_op(alu_op), .pc_sel(pc_sel), .upc(upc)
  );

  // {pcw, pcwc, addr_alu, mrd, mwr, irw, rw, wbm, rd, a, b[2], alu[2], pcs[2]}
  wire [15:0] dut_ctrl = {pc_write, pc_write_cond, addr_from_alu, mem_read,
                          mem_write, ir_write, reg_write, wb_from_mem, dest_rd,
                          a_from_reg, b_sel, alu_op, pc_sel};

  typedef struct {
    logic [3:0] st;
    string      tag;
  } item_t;

  item_t sb[$];

  function automatic logic [15:0] exp_ctrl(input logic [3:0] s);
    case (s)
      4'd0: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00};
      4'd1: return {10'b0, 2'b11, 2'b00, 2'b00};
      4'd2: return {9'b0, 1'b1, 2'b10, 2'b00, 2'b00};
      4'd3: return {2'b00,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 6'b0};
      4'd4: return {6'b0,1'b1,1'b1,1'b0,1'b0, 6'b0};
      4'd5: return {2'b00,1'b1,1'b0,1'b1,5'b0, 6'b0};
      4'd6: return {9'b0, 1'b1, 2'b00, 2'b10, 2'b00};
      4'd7: return {6'b0,1'b1,1'b0,1'b1,1'b0, 6'b0};
      4'd8: return {1'b0,1'b1,7'b0,1'b1, 2'b00, 2'b01, 2'b01};
      4'd9: return {1'b1, 9'b0, 2'b00, 2'b00, 2'b10};
      default: return 16'h0;
    endcase
  endfunction

  function automatic string ctrl_req(input logic [3:0] s);
    case (s)
      4'd0: return "R7";
      4'd1: return "R8";
      4'd2, 4'd6, 4'd8: return "R9";
      4'd9: return "R11";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: compare each expected item at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(upc == it.st, it.tag, "upc", int'(upc), int'(it.st));
      check(dut_ctrl == exp_ctrl(it.st), ctrl_req(it.st), "ctrl",
            int'(dut_ctrl), int'(exp_ctrl(it.st)));
    end
  end

  // Driver: walks one instruction from fetch back to fetch, pushing the
  // expected micro-address for each cycle; junk opcodes outside entries 1/2.
  task automatic run_instr(input logic [5:0] op_dec, input logic [5:0] op_mem,
                           input bit junk, input string jtag);
    logic [3:0] s = 4'd0;
    string tg = "R6";
    int guard = 0;
    do begin
      item_t it;
      logic [3:0] n;
      string nt;
      it.st  = s;
      it.tag = tg;
      if (s == 4'd1)      opcode = op_dec;
      else if (s == 4'd2) opcode = op_mem;
      else                opcode = junk ? JNK : op_dec;
      sb.push_back(it);
      case (s)
        4'd0: begin n = 4'd1; nt = junk ? jtag : "R2"; end
        4'd1: begin
          nt = "R3";
          if (op_dec == OPR)                      n = 4'd6;
          else if (op_dec == OPJ)                 n = 4'd9;
          else if (op_dec == OPB)                 n = 4'd8;
          else if (op_dec == OPL || op_dec == OPS) n = 4'd2;
          else begin n = 4'd0; nt = "R5"; end
        end
        4'd2: begin
          nt = "R4";
          if (op_mem == OPL)      n = 4'd3;
          else if (op_mem == OPS) n = 4'd5;
          else begin n = 4'd0; nt = "R5"; end
        end
        4'd3: begin n = 4'd4; nt = junk ? jtag : "R2"; end
        4'd6: begin n = 4'd7; nt = junk ? jtag : "R2"; end
        default: begin n = 4'd0; nt = "R6"; end
      endcase
      @(posedge clk); #1;
      s  = n;
      tg = nt;
      guard++;
    end while (s != 4'd0 && guard < 8);
  endtask

  initial begin
    #400000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(upc == 4'd0, "R1", "upc in reset", int'(upc), 0);
    check(dut_ctrl == exp_ctrl(4'd0), "R1", "ctrl in reset",
          int'(dut_ctrl), int'(exp_ctrl(4'd0)));
    @(posedge clk); #1;
    rst = 1'b0;

    run_instr(OPL, OPL, 1'b0, "R2");   // load
    run_instr(OPS, OPS, 1'b0, "R2");   // store
    run_instr(OPR, OPR, 1'b0, "R2");   // register format
    run_instr(OPB, OPB, 1'b0, "R2");   // branch
    run_instr(OPJ, OPJ, 1'b0, "R2");   // jump
    run_instr(6'h08, 6'h08, 1'b0, "R5"); // unlisted at dispatch 1
    run_instr(OPL, OPB, 1'b0, "R5");   // R5: unlisted at dispatch 2
    run_instr(OPS, OPL, 1'b0, "R4");   // R4: second table uses current opcode
    run_instr(OPL, OPS, 1'b0, "R4");
    run_instr(OPL, OPL, 1'b1, "R12");  // R12: junk opcode elsewhere
    run_instr(OPR, OPR, 1'b1, "R12");
    run_instr(OPS, OPS, 1'b1, "R12");

    // R1: reset in the middle of a load
    opcode = OPL;
    repeat (3) begin @(posedge clk); #1; end
    @(negedge clk);
    check(upc == 4'd3, "R1", "upc before reset", int'(upc), 3);
    @(posedge clk); #1;
    rst = 1'b1;
    opcode = OPR;
    @(negedge clk);
    check(upc == 4'd4, "R12", "upc before reset edge", int'(upc), 4);
    @(posedge clk); #1;
    @(negedge clk);
    check(upc == 4'd0, "R1", "upc after mid reset", int'(upc), 0);
    check(dut_ctrl == exp_ctrl(4'd0), "R1", "ctrl after mid reset",
          int'(dut_ctrl), int'(exp_ctrl(4'd0)));
    @(posedge clk); #1;
    @(negedge clk);
    check(upc == 4'd0, "R1", "upc held in reset", int'(upc), 0);
    @(posedge clk); #1;
    rst = 1'b0;

    run_instr(OPB, OPB, 1'b1, "R12");
    run_instr(OPJ, OPJ, 1'b0, "R2");

    @(negedge clk);
    check(sb.size() == 0, "R6", "scoreboard drained", sb.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule